// File: doc/BRIEF.md
# Wear-Limited Unary Event Counter

This block keeps an ever-growing event tally in a small bank of byte-wide storage cells that behave like nonvolatile memory: a bit can be raised from 0 to 1 freely, but returning any bit to 0 needs an erase of the whole bank. Every counted event raises exactly one more bit. Inside a cell the bits fill from the least significant end upward, so a single cell soaks up eight events between erases. The cells are taken in a reflected-binary (Gray) visiting order rather than in plain index order.

When every cell is saturated, the next event erases the bank, advances a wide epoch register, and on the following cycle raises the lowest bit of the first cell on behalf of that event. The binary tally is the epoch scaled by the bank capacity plus the number of raised bits. The block drives a one-hot per-cell write command with the new byte, a bank-wide erase command, the full cell image and the binary tally. An event strobe that lands during the erase cycle is held and applied one cycle later, so no event is dropped.

Top module: `wear_unary_counter`

## Requirements
- R1: Each applied event raises exactly one bit of `image_o`. Outside an erase no bit of `image_o` ever falls from 1 to 0.
- R2: While `rst_n` is low and after its release, every cell reads 0x00, `count_o` is 0, and `wr_en_o` and `erase_o` are 0.
- R3: A cell fills as a thermometer. The written byte is the old byte shifted left by one with bit 0 set, giving 0x01, 0x03, 0x07 and so on up to 0xFF.
- R4: With k bits raised (0 to 63), the event goes to cell g = s ^ (s >> 1), where s = k / 8. This gives the cell order 0, 1, 3, 2, 6, 7, 5, 4. Cell c occupies `image_o[8c+7:8c]`.
- R5: An event sampled at a clock edge updates `image_o` at that edge. From that edge until the next one, `wr_en_o` holds a one-hot mask with bit c set for the written cell and `wr_data_o` holds its new byte. `wr_en_o` is 0 in cycles with no write.
- R6: An event sampled while all cells read 0xFF clears the whole image and raises `erase_o` for one cycle, with `wr_en_o` at 0. At the next edge, with no further strobe, cell 0 is written with 0x01.
- R7: `count_o` equals epoch × 64 plus the number of set bits in `image_o`. Over a run it equals the number of strobes applied, and it never decreases.
- R8: A strobe sampled in the cycle in which `erase_o` is high is held. It is applied at the edge after the owed 0x01 write, and no strobe is lost during back-to-back bursts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset that also erases every cell |
| inc_i | input | 1 | Event strobe, one event per high cycle |
| wr_en_o | output | NUM_CELLS | One-hot write command for the cell modified at the last edge |
| wr_data_o | output | CELL_W | New byte written to that cell |
| erase_o | output | 1 | Bank-wide erase command issued at the last edge |
| image_o | output | NUM_CELLS*CELL_W | Current contents of all cells, cell c in bits [c*CELL_W +: CELL_W] |
| count_o | output | EPOCH_W+log2(NUM_CELLS*CELL_W) | Binary event tally |

## Verification
Two functions can land in the same cycle. The first is the bank erase with its owed first-bit write. The second is the acceptance of a fresh event strobe. The bench provokes this in two ways: it holds the strobe high across the erase cycle, and it runs a long unbroken burst that crosses an epoch boundary. It then judges the result cycle by cycle through the erase flag and the 0x01 and 0x03 writes to cell 0, and after the burst drains it compares the tally and the cell image against arithmetic on the number of strobes.

// File: rtl/wuc_pkg.sv
package wuc_pkg;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_ERASE = 2'd2
  } wuc_act_e;

  // Reflected-binary code of a visiting step.
  function automatic logic [31:0] gray_of(input logic [31:0] v);
    return v ^ (v >> 1);
  endfunction

endpackage

// File: rtl/wuc_cell_bank.sv
module wuc_cell_bank #(
  parameter int NUM_CELLS = 8,
  parameter int CELL_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CELLS-1:0]          wr_en_i,
  input  logic [CELL_W-1:0]             wr_data_i,
  input  logic                          erase_i,
  output logic [NUM_CELLS*CELL_W-1:0]   image_o
);

  logic wr_any;
  assign wr_any = |wr_en_i;

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    logic [CELL_W-1:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cell_q <= '0;
      else if (erase_i)    cell_q <= '0;
      else if (wr_en_i[c]) cell_q <= wr_data_i;
    end
    assign image_o[c*CELL_W +: CELL_W] = cell_q;
  end

  // R1: a write raises exactly one bit of the image
  assert_one_bit_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && !erase_i) |=> ($countones(image_o ^ $past(image_o)) == 1));

  // R1: no bit falls without an erase
  assert_no_bit_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_i |=> ((image_o & ~$past(image_o)) == image_o - $past(image_o)) || ((~image_o & $past(image_o)) == '0));

  // R6: an erase leaves the bank blank
  assert_erase_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_i |=> (image_o == '0));

endmodule

// File: rtl/wuc_sequencer.sv
module wuc_sequencer
  import wuc_pkg::*;
#(
  parameter int NUM_CELLS = 8,
  parameter int CELL_W    = 8,
  parameter int PEND_W    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          inc_i,
  input  logic [NUM_CELLS*CELL_W-1:0]   image_i,
  output logic [NUM_CELLS-1:0]          cmd_wr_en_o,
  output logic [CELL_W-1:0]             cmd_data_o,
  output logic                          cmd_erase_o,
  output logic [NUM_CELLS-1:0]          wr_en_o,
  output logic [CELL_W-1:0]             wr_data_o,
  output logic                          erase_o
);

  localparam int TOTAL_BITS = NUM_CELLS * CELL_W;
  localparam int IDX_W      = $clog2(NUM_CELLS);
  localparam int TOT_W      = $clog2(TOTAL_BITS + 1);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  // Thermometer advance of one cell byte.
  function automatic logic [CELL_W-1:0] thermo_step(input logic [CELL_W-1:0] b);
    return {b[CELL_W-2:0], 1'b1};
  endfunction

  logic [TOT_W-1:0]  total;
  logic              full;
  logic [IDX_W-1:0]  step_idx;
  logic [IDX_W-1:0]  cell_sel;
  logic [CELL_W-1:0] old_byte;
  logic              owe_q;
  logic [PEND_W-1:0] pend_q;
  logic              have_req;
  logic              take;
  wuc_act_e          act;

  assign total    = TOT_W'($countones(image_i));
  assign full     = (total == TOT_W'(TOTAL_BITS));
  assign step_idx = IDX_W'(total / TOT_W'(CELL_W));
  assign cell_sel = IDX_W'(gray_of(32'(step_idx)));
  assign old_byte = image_i[cell_sel*CELL_W +: CELL_W];

  // An owed write after an erase goes first; then held strobes, then a fresh one.
  assign have_req = owe_q || (pend_q != '0) || inc_i;
  assign take     = have_req && !owe_q;

  always_comb begin
    act = ACT_NONE;
    if (have_req) act = full ? ACT_ERASE : ACT_WRITE;
  end

  assign cmd_erase_o = (act == ACT_ERASE);
  assign cmd_wr_en_o = (act == ACT_WRITE) ? (NUM_CELLS'(1) << cell_sel) : '0;
  assign cmd_data_o  = (act == ACT_WRITE) ? thermo_step(old_byte) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owe_q     <= 1'b0;
      pend_q    <= '0;
      wr_en_o   <= '0;
      wr_data_o <= '0;
      erase_o   <= 1'b0;
    end else begin
      owe_q     <= cmd_erase_o;
      pend_q    <= pend_q + PEND_W'(inc_i) - PEND_W'(take);
      wr_en_o   <= cmd_wr_en_o;
      wr_data_o <= cmd_data_o;
      erase_o   <= cmd_erase_o;
    end
  end

  // R5: at most one cell is written per cycle
  assert_one_cell_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en_o));

  // R6: an erase cycle carries no write, and cell 0 is written next
  assert_erase_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_o |-> (wr_en_o == '0));
  assert_owed_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_o |=> (wr_en_o[0] && wr_data_o == CELL_W'(1)));

  // R8: the hold register never wraps
  assert_no_pend_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_i && !take && pend_q == PEND_MAX));

endmodule

// File: rtl/wuc_tally.sv
module wuc_tally #(
  parameter int NUM_CELLS = 8,
  parameter int CELL_W    = 8,
  parameter int EPOCH_W   = 16
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         erase_i,
  input  logic [NUM_CELLS*CELL_W-1:0]                  image_i,
  output logic [EPOCH_W+$clog2(NUM_CELLS*CELL_W)-1:0]  count_o
);

  localparam int TOTAL_BITS = NUM_CELLS * CELL_W;
  localparam int LOG_TOT    = $clog2(TOTAL_BITS);
  localparam int COUNT_W    = EPOCH_W + LOG_TOT;

  // Epoch scaled by bank capacity, plus raised bits.
  function automatic logic [COUNT_W-1:0] tally_of(input logic [EPOCH_W-1:0] ep,
                                                  input logic [NUM_CELLS*CELL_W-1:0] img);
    return {ep, LOG_TOT'(0)} + COUNT_W'($countones(img));
  endfunction

  logic [EPOCH_W-1:0] epoch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       epoch_q <= '0;
    else if (erase_i) epoch_q <= epoch_q + 1'b1;
  end

  assign count_o = tally_of(epoch_q, image_i);

  // R7: the tally never steps backward
  assert_count_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(&epoch_q) |=> (count_o >= $past(count_o)));

endmodule

// File: rtl/wear_unary_counter.sv
module wear_unary_counter #(
  parameter int NUM_CELLS = 8,
  parameter int CELL_W    = 8,
  parameter int EPOCH_W   = 16,
  parameter int PEND_W    = 2
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          inc_i,
  output logic [NUM_CELLS-1:0]                          wr_en_o,
  output logic [CELL_W-1:0]                             wr_data_o,
  output logic                                          erase_o,
  output logic [NUM_CELLS*CELL_W-1:0]                   image_o,
  output logic [EPOCH_W+$clog2(NUM_CELLS*CELL_W)-1:0]   count_o
);

  // Named internal command wires for the assertions.
  logic [NUM_CELLS-1:0] cmd_wr_en;
  logic [CELL_W-1:0]    cmd_data;
  logic                 cmd_erase;

  wuc_sequencer #(.NUM_CELLS(NUM_CELLS), .CELL_W(CELL_W), .PEND_W(PEND_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc_i       (inc_i),
    .image_i     (image_o),
    .cmd_wr_en_o (cmd_wr_en),
    .cmd_data_o  (cmd_data),
    .cmd_erase_o (cmd_erase),
    .wr_en_o     (wr_en_o),
    .wr_data_o   (wr_data_o),
    .erase_o     (erase_o)
  );

  wuc_cell_bank #(.NUM_CELLS(NUM_CELLS), .CELL_W(CELL_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (cmd_wr_en),
    .wr_data_i (cmd_data),
    .erase_i   (cmd_erase),
    .image_o   (image_o)
  );

  wuc_tally #(.NUM_CELLS(NUM_CELLS), .CELL_W(CELL_W), .EPOCH_W(EPOCH_W)) u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .erase_i (cmd_erase),
    .image_i (image_o),
    .count_o (count_o)
  );

  // R2: reset leaves no command pending
  assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (wr_en_o == '0 && !erase_o));

endmodule

// File: tb/wear_unary_counter_bench.sv
module wear_unary_counter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc = 1'b0;
  logic [7:0]  wr_en;
  logic [7:0]  wr_data;
  logic        erase;
  logic [63:0] image;
  logic [21:0] count;

  int n_checks = 0;
  int n_fail   = 0;
  int c        = 0;   // strobes applied so far

  always #2 clk = ~clk;

  wear_unary_counter u_wear_unary_counter (
    .clk(clk), .rst_n(rst_n), .inc_i(inc), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .erase_o(erase), .image_o(image), .count_o(count)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Raised bits in the current epoch after cnt strobes.
  function automatic int fill_of(input int cnt);
    return (cnt == 0) ? 0 : ((cnt - 1) % 64) + 1;
  endfunction

  function automatic logic [63:0] model_image(input int cnt);
    logic [63:0] img = '0;
    int r = fill_of(cnt);
    for (int s = 0; s < 8; s++) begin
      int g = s ^ (s >> 1);
      int ones = r - 8 * s;
      if (ones < 0) ones = 0;
      if (ones > 8) ones = 8;
      img[g*8 +: 8] = 8'((1 << ones) - 1);
    end
    return img;
  endfunction

  // Cycle monitor: single-bit steps, no cleared bits, tally tracks image.
  logic [63:0] prev_img;
  logic [21:0] prev_cnt;
  bit          mon_valid = 0;
  always @(negedge clk) begin
    if (!rst_n) mon_valid <= 0;
    else begin
      if (mon_valid) begin
        if (erase) chk(image == 0, "R6", "image after erase", image, 0);
        else begin
          chk($countones(image ^ prev_img) <= 1, "R1", "bits changed per cycle",
              $countones(image ^ prev_img), 1);
          chk((prev_img & ~image) == 0, "R1", "bits cleared", prev_img & ~image, 0);
        end
        chk(count >= prev_cnt, "R7", "count monotonic", count, prev_cnt);
      end
      chk(count[5:0] == 6'($countones(image)), "R7", "count low bits vs image",
          count[5:0], $countones(image));
      prev_img  <= image;
      prev_cnt  <= count;
      mon_valid <= 1;
    end
  end

  task automatic check_state(input string req);
    chk(count == 22'(c), req, "count", count, c);
    chk(image == model_image(c), req, "image", image, model_image(c));
  endtask

  // One strobe from a negedge, with exact per-cycle checks.
  task automatic strobe_one(input int gap);
    int r_prev = fill_of(c);
    inc = 1'b1;
    @(negedge clk);
    inc = 1'b0;
    if (r_prev == 64) begin
      chk(erase == 1'b1, "R6", "erase flag", erase, 1);
      chk(wr_en == 0, "R6", "no write in erase cycle", wr_en, 0);
      chk(count == 22'(c), "R7", "count in erase cycle", count, c);
      @(negedge clk);
      chk(wr_en == 8'h01, "R6", "owed write cell", wr_en, 1);
      chk(wr_data == 8'h01, "R6", "owed write data", wr_data, 1);
    end else begin
      int s = r_prev / 8;
      int g = s ^ (s >> 1);
      chk(wr_en == 8'(1 << g), "R4", "gray cell select", wr_en, 1 << g);
      chk(wr_data == 8'((1 << (r_prev % 8 + 1)) - 1), "R3", "thermometer byte",
          wr_data, (1 << (r_prev % 8 + 1)) - 1);
      chk(erase == 1'b0, "R5", "no erase on write", erase, 0);
    end
    c++;
    check_state("R1");
    repeat (gap) @(negedge clk);
    if (gap > 0) chk(wr_en == 0 && erase == 0, "R5", "idle command", wr_en, 0);
  endtask

  task automatic check_reset();
    chk(image == 0, "R2", "image after reset", image, 0);
    chk(count == 0, "R2", "count after reset", count, 0);
    chk(wr_en == 0, "R2", "write cmd after reset", wr_en, 0);
    chk(erase == 0, "R2", "erase after reset", erase, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check_reset();

    // Sweep over three epochs with mixed idle gaps.
    for (int i = 0; i < 200; i++) strobe_one(i % 3);

    // Fill to saturation, then hold the strobe across the erase cycle (R8).
    while (fill_of(c) != 64) strobe_one(0);
    inc = 1'b1;
    @(negedge clk);
    chk(erase == 1'b1, "R8", "erase before held strobe", erase, 1);
    @(negedge clk);
    inc = 1'b0;
    chk(wr_en == 8'h01 && wr_data == 8'h01, "R8", "owed write first", wr_data, 1);
    @(negedge clk);
    chk(wr_en == 8'h01, "R8", "held strobe cell", wr_en, 1);
    chk(wr_data == 8'h03, "R8", "held strobe byte", wr_data, 3);
    c += 2;
    check_state("R8");

    // Unbroken burst crossing an epoch boundary (R8, R7).
    inc = 1'b1;
    repeat (100) @(negedge clk);
    inc = 1'b0;
    c += 100;
    repeat (4) @(negedge clk);
    check_state("R8");
    chk(count == 22'(c), "R7", "count equals strobes", count, c);

    // Mid-run reset clears everything (R2).
    rst_n = 1'b0;
    @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    c = 0;
    @(negedge clk);
    check_reset();
    for (int i = 0; i < 70; i++) strobe_one(1);
    check_state("R7");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule